// File: doc/BRIEF.md
# Paged Multi-Mode Register Access Port

This block is the host-facing front end of a bank of paged control and status registers. Two static strap inputs pick how the host talks to it. One choice is a non-multiplexed parallel port with an 8-bit data bus, a 5-bit address/command bus, a read/write line, a chip select and a data strobe. The other is a three-wire serial port with a clock, a data line and a chip select; it works out which of two bit-order conventions the host uses from the clock level at the moment chip select falls. A third strap setting, a time-division control-stream mode, is not served here and is only flagged.

Every register access is two steps. The host first writes a command/address register to choose a page, then reads or writes registers within that page. The block turns each host access into a single-cycle strobe on an internal page/address/data bus, returns read data to the host, and holds an active-low interrupt line asserted from an event until the host reads the status page.

All host-side inputs pass through two-flop synchronizers into the system clock domain. Address, data and read/write must be stable before the data strobe is asserted.

Top module: `ctrl_port_paged`

## Requirements
- R1: After reset the selected page is 0, the interrupt output is high, both output enables are low, no bus strobe is issued and the mode-unsupported flag follows the straps only.
- R2: Strap decode: `sel_serial`=0 gives the parallel port; `sel_serial`=1 with `sel_stream`=0 gives the serial port; both 1 raise `mode_unsup` and no host access of either port reaches the internal bus.
- R3: A parallel or serial access with address bit 4 equal to 0 targets the command/address register; a write stores the page number, and a read returns the page in data bits 3..0 with bits 7..4 zero.
- R4: An access with address bit 4 equal to 1 issues one `bus_wr` or `bus_rd` strobe carrying the selected page and address bits 3..0 (and the write data); a read returns `bus_rdata` to the host.
- R5: Writing a page value of 14 or greater to the command/address register is ignored and the previous page is retained.
- R6: In serial mode the clock level at chip-select fall selects the convention: high selects LSB-first bit order, low selects MSB-first bit order; the same order applies to every bit in and out of that transaction.
- R7: A serial transaction is 16 clock periods: a command byte (bit 7 = 1 read, 0 write; bits 4..0 address) then a data byte. Input bits are taken on rising clock edges; on a read the output bits change on falling edges, the data line is driven during the data byte, and the register read happens after the command byte.
- R8: A pulse on `irq_event` drives `irq_n` low; it stays low through other accesses until a register read (address bit 4 = 1) with page 13 selected, after which it returns high.
- R9: The parallel data output enable is high only while the parallel port is selected and chip select, data strobe and read (`par_rw`=1) are all asserted.
- R10: Activity on the port that is not selected by the straps has no effect on the page or the internal bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_serial | input | 1 | Strap: 0 parallel port, 1 serial or stream mode |
| sel_stream | input | 1 | Strap: with `sel_serial`=1, 1 selects the unsupported stream mode |
| par_cs_n | input | 1 | Parallel chip select, active low |
| par_ds_n | input | 1 | Parallel data strobe, active low |
| par_rw | input | 1 | Parallel direction, 1 read, 0 write |
| par_addr | input | 5 | Parallel address/command bus |
| par_din | input | 8 | Parallel write data from host |
| par_dout | output | 8 | Parallel read data to host |
| par_doe | output | 1 | Parallel data output enable |
| ser_clk | input | 1 | Serial clock from host |
| ser_cs_n | input | 1 | Serial chip select, active low |
| ser_din | input | 1 | Serial data from host |
| ser_dout | output | 1 | Serial data to host |
| ser_doe | output | 1 | Serial data output enable |
| mode_unsup | output | 1 | Straps select the unsupported stream mode |
| irq_event | input | 1 | Interrupt event pulse from the register bank |
| irq_n | output | 1 | Interrupt request, active low |
| bus_page | output | 4 | Selected page |
| bus_addr | output | 4 | Register address within the page |
| bus_wdata | output | 8 | Register write data |
| bus_wr | output | 1 | One-cycle register write strobe |
| bus_rd | output | 1 | One-cycle register read strobe |
| bus_rdata | input | 8 | Register read data, valid in the strobe cycle |

## Verification
The two-step access is driven through the parallel port, through the serial port in the LSB-first convention and in the MSB-first convention, using a data value whose bit-reversal differs from itself, so a swapped bit order or a wrong convention choice shows up as a wrong byte. Command/address reads after writes of legal, boundary (13, 14) and far out-of-range page values tell the page-update rule apart from a plain store. Accesses on the unselected port and in the stream strap setting, with a scoreboard that rejects any unexpected write strobe, separate gating faults from decode faults, while reads of a non-status page and then of page 13 tell a held interrupt from one cleared by any read.

// File: rtl/cport_pkg.sv
// Package: shared widths and the access request passed from a host port
// to the page controller. Assumes one access at a time per port.
package cport_pkg;
    parameter int DW = 8;   // host data width
    parameter int AW = 5;   // host address/command width

    typedef enum logic [1:0] {
        MODE_PAR   = 2'd0,
        MODE_SER   = 2'd1,
        MODE_UNSUP = 2'd2
    } port_mode_e;

    typedef struct packed {
        logic          valid;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } acc_req_t;
endpackage

// File: rtl/cport_sync.sv
// Two-flop synchronizer for a bundle of independent single-bit host lines.
// Assumes each bit is sampled on its own; not for multi-bit values.
module cport_sync #(
    parameter int         W       = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Two register stages into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/cport_par.sv
// Parallel host port. An access is taken on the synchronized falling edge
// of the data strobe while chip select is low. Assumes address, data and
// direction are stable from before the strobe falls until it rises.
module cport_par
    import cport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cs_n,
    input  logic          ds_n,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rdata_in,
    output acc_req_t      req,
    output logic [DW-1:0] dout,
    output logic          doe
);
    logic [1:0]    ctl_s;
    logic          ds_prev_q;
    logic          strobe;
    logic [DW-1:0] rd_q;

    cport_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, ds_n}),
        .q    (ctl_s)
    );

    // Remember the previous strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ds_prev_q <= 1'b1;
        else        ds_prev_q <= ctl_s[0];
    end

    assign strobe = en && ds_prev_q && !ctl_s[0] && !ctl_s[1];

    // Build the access request for the page controller.
    always_comb begin
        req.valid = strobe;
        req.wr    = !rw;
        req.addr  = addr;
        req.wdata = wdata;
    end

    // Capture read data in the access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                rd_q <= '0;
        else if (strobe && rw)     rd_q <= rdata_in;
    end

    assign dout = rd_q;
    assign doe  = en && !cs_n && rw && !ds_n;
endmodule

// File: rtl/cport_ser.sv
// Serial host port. The clock level at chip-select fall picks the bit
// order (high: LSB-first, low: MSB-first). Input bits are taken on rising
// clock edges, output bits change on falling edges. A frame is a command
// byte then a data byte. Assumes the host clock is much slower than clk.
module cport_ser
    import cport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          din,
    input  logic [DW-1:0] rdata_in,
    output acc_req_t      req,
    output logic          dout,
    output logic          doe
);
    localparam int CMD_BITS = DW;
    localparam int BITS     = 2 * DW;
    localparam int CW       = $clog2(BITS + 1);

    logic [2:0]    in_s;
    logic          s_cs_n, s_clk, s_din;
    logic          clk_prev_q, cs_prev_q;
    logic          lsb_first_q, active_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] cmd_q, data_q, tx_q;
    logic [DW-1:0] cmd_nxt, data_nxt;
    logic          dout_q, doe_q;
    logic          cs_fall, rise, fall;
    logic          cmd_done, frame_done;

    cport_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs_n, sclk, din}),
        .q    (in_s)
    );
    assign {s_cs_n, s_clk, s_din} = in_s;

    // Previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b1;
            cs_prev_q  <= 1'b1;
        end else begin
            clk_prev_q <= s_clk;
            cs_prev_q  <= s_cs_n;
        end
    end

    assign cs_fall = en && cs_prev_q && !s_cs_n;
    assign rise    = active_q && !s_cs_n && !cs_fall && s_clk && !clk_prev_q;
    assign fall    = active_q && !s_cs_n && !cs_fall && !s_clk && clk_prev_q;

    // Next shift values in the detected bit order.
    assign cmd_nxt  = lsb_first_q ? {s_din, cmd_q[DW-1:1]}  : {cmd_q[DW-2:0], s_din};
    assign data_nxt = lsb_first_q ? {s_din, data_q[DW-1:1]} : {data_q[DW-2:0], s_din};

    assign cmd_done   = rise && (cnt_q == CW'(CMD_BITS - 1));
    assign frame_done = rise && (cnt_q == CW'(BITS - 1));

    // Issue the read after the command byte, the write after the data byte.
    always_comb begin
        req.valid = (cmd_done && cmd_nxt[DW-1]) || (frame_done && !cmd_q[DW-1]);
        req.wr    = frame_done;
        req.addr  = cmd_done ? cmd_nxt[AW-1:0] : cmd_q[AW-1:0];
        req.wdata = data_nxt;
    end

    // Frame state: convention, bit count and shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsb_first_q <= 1'b0;
            active_q    <= 1'b0;
            cnt_q       <= '0;
            cmd_q       <= '0;
            data_q      <= '0;
        end else if (!en || s_cs_n) begin
            active_q <= 1'b0;
        end else if (cs_fall) begin
            lsb_first_q <= s_clk;
            active_q    <= 1'b1;
            cnt_q       <= '0;
            cmd_q       <= '0;
            data_q      <= '0;
        end else if (rise && cnt_q < CW'(BITS)) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q < CW'(CMD_BITS)) cmd_q  <= cmd_nxt;
            else                       data_q <= data_nxt;
        end
    end

    // Output shifter: load read data, shift one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= '0;
            dout_q <= 1'b0;
            doe_q  <= 1'b0;
        end else if (!en || s_cs_n) begin
            doe_q <= 1'b0;
        end else if (cmd_done && cmd_nxt[DW-1]) begin
            tx_q <= rdata_in;
        end else if (fall && cmd_q[DW-1] && cnt_q >= CW'(CMD_BITS) && cnt_q < CW'(BITS)) begin
            dout_q <= lsb_first_q ? tx_q[0] : tx_q[DW-1];
            tx_q   <= lsb_first_q ? (tx_q >> 1) : (tx_q << 1);
            doe_q  <= 1'b1;
        end
    end

    assign dout = dout_q;
    assign doe  = doe_q;

    assert_bitcnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(BITS));
    assert_oe_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(doe_q) |-> cmd_q[DW-1]);
endmodule

// File: rtl/cport_page.sv
// Page controller: holds the command/address (page) register, turns
// register-space requests into one-cycle bus strobes, returns read data
// and keeps the interrupt pending until the status page is read.
module cport_page
    import cport_pkg::*;
#(
    parameter int NUM_PAGES   = 14,
    parameter int STATUS_PAGE = 13,
    localparam int PW         = $clog2(NUM_PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  acc_req_t      req,
    input  logic          irq_event,
    input  logic [DW-1:0] bus_rdata,
    output logic [PW-1:0] bus_page,
    output logic [AW-2:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wr,
    output logic          bus_rd,
    output logic [DW-1:0] rdata,
    output logic          irq_n
);
    logic [PW-1:0] page_q;
    logic          pend_q;
    logic          car_wr, reg_acc, page_ok, status_rd;

    assign car_wr    = req.valid && req.wr && !req.addr[AW-1];
    assign reg_acc   = req.valid && req.addr[AW-1];
    assign page_ok   = req.wdata < DW'(NUM_PAGES);
    assign status_rd = bus_rd && (page_q == PW'(STATUS_PAGE));

    // Page register: legal page numbers only.
    always_ff @(posedge clk) begin
        if (!rst_n)                  page_q <= '0;
        else if (car_wr && page_ok)  page_q <= req.wdata[PW-1:0];
    end

    // Interrupt pending: event sets, status-page read clears.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (irq_event)  pend_q <= 1'b1;
        else if (status_rd)  pend_q <= 1'b0;
    end

    assign bus_page  = page_q;
    assign bus_addr  = req.addr[AW-2:0];
    assign bus_wdata = req.wdata;
    assign bus_wr    = reg_acc && req.wr;
    assign bus_rd    = reg_acc && !req.wr;
    assign rdata     = req.addr[AW-1] ? bus_rdata : {{(DW-PW){1'b0}}, page_q};
    assign irq_n     = !pend_q;

    assert_page_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        page_q < PW'(NUM_PAGES));
    assert_bad_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (car_wr && !page_ok) |=> $stable(page_q));
    assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_event |=> !irq_n);
    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !(bus_rd && bus_page == PW'(STATUS_PAGE))) |=> !irq_n);
endmodule

// File: rtl/ctrl_port_paged.sv
// Top: decodes the mode straps, enables one host port, and routes its
// requests to the page controller. Assumes the straps are static while
// any host transaction is in progress.
module ctrl_port_paged
    import cport_pkg::*;
#(
    parameter int NUM_PAGES   = 14,
    parameter int STATUS_PAGE = 13,
    localparam int PW         = $clog2(NUM_PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_serial,
    input  logic          sel_stream,
    input  logic          par_cs_n,
    input  logic          par_ds_n,
    input  logic          par_rw,
    input  logic [AW-1:0] par_addr,
    input  logic [DW-1:0] par_din,
    output logic [DW-1:0] par_dout,
    output logic          par_doe,
    input  logic          ser_clk,
    input  logic          ser_cs_n,
    input  logic          ser_din,
    output logic          ser_dout,
    output logic          ser_doe,
    output logic          mode_unsup,
    input  logic          irq_event,
    output logic          irq_n,
    output logic [PW-1:0] bus_page,
    output logic [AW-2:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wr,
    output logic          bus_rd,
    input  logic [DW-1:0] bus_rdata
);
    port_mode_e    mode;
    acc_req_t      par_req, ser_req, req;
    logic [DW-1:0] rdata;

    // Strap decode.
    always_comb begin
        if (!sel_serial)      mode = MODE_PAR;
        else if (!sel_stream) mode = MODE_SER;
        else                  mode = MODE_UNSUP;
    end

    assign mode_unsup = (mode == MODE_UNSUP);

    cport_par u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mode == MODE_PAR),
        .cs_n    (par_cs_n),
        .ds_n    (par_ds_n),
        .rw      (par_rw),
        .addr    (par_addr),
        .wdata   (par_din),
        .rdata_in(rdata),
        .req     (par_req),
        .dout    (par_dout),
        .doe     (par_doe)
    );

    cport_ser u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mode == MODE_SER),
        .sclk    (ser_clk),
        .cs_n    (ser_cs_n),
        .din     (ser_din),
        .rdata_in(rdata),
        .req     (ser_req),
        .dout    (ser_dout),
        .doe     (ser_doe)
    );

    // Route the request of the selected port.
    always_comb begin
        req = (mode == MODE_SER) ? ser_req : par_req;
    end

    cport_page #(
        .NUM_PAGES  (NUM_PAGES),
        .STATUS_PAGE(STATUS_PAGE)
    ) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .irq_event(irq_event),
        .bus_rdata(bus_rdata),
        .bus_page (bus_page),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .rdata    (rdata),
        .irq_n    (irq_n)
    );

    assert_unsup_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_unsup |-> !bus_wr && !bus_rd);
    assert_par_oe_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        par_doe |-> !sel_serial && par_rw);
    assert_port_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_req.valid && ser_req.valid));
endmodule

// File: tb/test_ctrl_port_paged.sv
// Scoreboard bench: driver tasks push expected bus writes into a queue,
// a monitor pops them on each write strobe; reads are compared at the ports.
module test_ctrl_port_paged;
    localparam int H = 8;  // half serial bit, in clk cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_serial = 1'b0, sel_stream = 1'b0;
    logic       par_cs_n = 1'b1, par_ds_n = 1'b1, par_rw = 1'b1;
    logic [4:0] par_addr = '0;
    logic [7:0] par_din = '0;
    logic [7:0] par_dout;
    logic       par_doe;
    logic       ser_clk = 1'b1, ser_cs_n = 1'b1, ser_din = 1'b0;
    logic       ser_dout, ser_doe;
    logic       mode_unsup;
    logic       irq_event = 1'b0;
    logic       irq_n;
    logic [3:0] bus_page, bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       bus_wr, bus_rd;

    int vectors = 0;
    int miscompares = 0;

    typedef struct { logic [3:0] p; logic [3:0] a; logic [7:0] d; } wr_item_t;
    wr_item_t exp_q[$];
    logic [7:0] bank [256];

    always #4 clk = ~clk;

    ctrl_port_paged i_ctrl_port_paged (
        .clk(clk), .rst_n(rst_n), .sel_serial(sel_serial), .sel_stream(sel_stream),
        .par_cs_n(par_cs_n), .par_ds_n(par_ds_n), .par_rw(par_rw), .par_addr(par_addr),
        .par_din(par_din), .par_dout(par_dout), .par_doe(par_doe),
        .ser_clk(ser_clk), .ser_cs_n(ser_cs_n), .ser_din(ser_din), .ser_dout(ser_dout),
        .ser_doe(ser_doe), .mode_unsup(mode_unsup), .irq_event(irq_event), .irq_n(irq_n),
        .bus_page(bus_page), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    assign bus_rdata = bank[{bus_page, bus_addr}];

    function automatic logic [7:0] init_val(int idx);
        return 8'(idx) ^ 8'h5A;
    endfunction

    // Register bank model and write monitor.
    always @(posedge clk) begin
        wr_item_t e;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) bank[i] <= init_val(i);
        end else if (bus_wr) begin
            bank[{bus_page, bus_addr}] <= bus_wdata;
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R2/R10 unexpected write: actual %0h/%0h/%0h expected none",
                         bus_page, bus_addr, bus_wdata);
            end else begin
                e = exp_q.pop_front();
                if (e.p !== bus_page || e.a !== bus_addr || e.d !== bus_wdata) begin
                    miscompares++;
                    $display("FAIL R4 write strobe: actual %0h/%0h/%0h expected %0h/%0h/%0h",
                             bus_page, bus_addr, bus_wdata, e.p, e.a, e.d);
                end
            end
        end
    end

    task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic expect_wr(logic [3:0] p, logic [3:0] a, logic [7:0] d);
        wr_item_t e;
        e.p = p; e.a = a; e.d = d;
        exp_q.push_back(e);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // Parallel access; returns read data and the output enable seen mid-strobe.
    task automatic par_acc(logic rw, logic [4:0] a, logic [7:0] d,
                           output logic [7:0] rd, output logic oe);
        @(negedge clk);
        par_rw = rw; par_addr = a; par_din = d;
        par_cs_n = 1'b0;
        wait_n(3);
        par_ds_n = 1'b0;
        wait_n(8);
        rd = par_dout;
        oe = par_doe;
        par_ds_n = 1'b1;
        wait_n(3);
        par_cs_n = 1'b1;
        par_rw = 1'b1;
        wait_n(3);
    endtask

    // Serial transaction in either convention.
    task automatic ser_xfer(logic lsb, logic [7:0] cmd, logic [7:0] wd,
                            output logic [7:0] rd, output logic oe);
        logic b;
        rd = '0; oe = 1'b0;
        @(negedge clk);
        ser_clk = lsb;
        wait_n(H);
        ser_cs_n = 1'b0;
        wait_n(H);
        for (int i = 0; i < 16; i++) begin
            if (i < 8) b = lsb ? cmd[i] : cmd[7-i];
            else       b = lsb ? wd[i-8] : wd[15-i];
            if (lsb) ser_clk = 1'b0;
            ser_din = b;
            wait_n(H);
            if (i >= 8) begin
                if (lsb) rd[i-8]  = ser_dout;
                else     rd[15-i] = ser_dout;
                if (i == 8) oe = ser_doe;
            end
            ser_clk = 1'b1;
            wait_n(H);
            if (!lsb) ser_clk = 1'b0;
        end
        wait_n(H);
        ser_cs_n = 1'b1;
        wait_n(H);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic       oe;
        wait_n(10);
        rst_n = 1'b1;
        wait_n(4);

        // R1: reset state
        chk("R1 irq_n", 8'(irq_n), 8'h1);
        chk("R1 par_doe", 8'(par_doe), 8'h0);
        chk("R1 ser_doe", 8'(ser_doe), 8'h0);
        chk("R1 mode_unsup", 8'(mode_unsup), 8'h0);
        chk("R1 bus strobes", {6'b0, bus_wr, bus_rd}, 8'h0);
        par_acc(1'b1, 5'h00, 8'h00, rd, oe);
        chk("R1 page after reset", rd, 8'h00);

        // R3: page select and read-back; R9: enables
        par_acc(1'b0, 5'h00, 8'h05, rd, oe);
        chk("R9 no oe on write", 8'(oe), 8'h0);
        par_acc(1'b1, 5'h00, 8'h00, rd, oe);
        chk("R3 page read-back", rd, 8'h05);
        chk("R9 oe on read", 8'(oe), 8'h1);
        chk("R9 oe after strobe", 8'(par_doe), 8'h0);

        // R4: register write and read in the selected page
        expect_wr(4'h5, 4'h3, 8'h3C);
        par_acc(1'b0, 5'h13, 8'h3C, rd, oe);
        par_acc(1'b1, 5'h13, 8'h00, rd, oe);
        chk("R4 read written reg", rd, 8'h3C);
        par_acc(1'b1, 5'h14, 8'h00, rd, oe);
        chk("R4 read untouched reg", rd, init_val(16 * 5 + 4));

        // R5: out-of-range pages are ignored
        par_acc(1'b0, 5'h00, 8'd14, rd, oe);
        par_acc(1'b1, 5'h00, 8'h00, rd, oe);
        chk("R5 page 14 ignored", rd, 8'h05);
        par_acc(1'b0, 5'h00, 8'hFF, rd, oe);
        par_acc(1'b1, 5'h00, 8'h00, rd, oe);
        chk("R5 page FF ignored", rd, 8'h05);
        par_acc(1'b0, 5'h00, 8'd13, rd, oe);
        par_acc(1'b1, 5'h00, 8'h00, rd, oe);
        chk("R5 page 13 accepted", rd, 8'd13);

        // R8: interrupt held until a status-page read
        par_acc(1'b0, 5'h00, 8'h02, rd, oe);
        @(negedge clk); irq_event = 1'b1;
        @(negedge clk); irq_event = 1'b0;
        wait_n(2);
        chk("R8 irq asserted", 8'(irq_n), 8'h0);
        par_acc(1'b1, 5'h11, 8'h00, rd, oe);
        chk("R8 irq held on other page", 8'(irq_n), 8'h0);
        par_acc(1'b0, 5'h00, 8'd13, rd, oe);
        chk("R8 irq held on page select", 8'(irq_n), 8'h0);
        par_acc(1'b1, 5'h10, 8'h00, rd, oe);
        chk("R8 irq cleared by status read", 8'(irq_n), 8'h1);

        // R6/R7: serial port in both conventions
        sel_serial = 1'b1; sel_stream = 1'b0;
        wait_n(4);
        ser_xfer(1'b1, 8'h00, 8'h07, rd, oe);
        ser_xfer(1'b0, 8'h80, 8'h00, rd, oe);
        chk("R6 MSB-first page read", rd, 8'h07);
        chk("R7 serial oe during read", 8'(oe), 8'h1);
        expect_wr(4'h7, 4'h9, 8'h96);
        ser_xfer(1'b1, 8'h19, 8'h96, rd, oe);
        chk("R7 serial oe off on write", 8'(oe), 8'h0);
        ser_xfer(1'b0, 8'h99, 8'h00, rd, oe);
        chk("R6 MSB-first reg read", rd, 8'h96);
        ser_xfer(1'b1, 8'h99, 8'h00, rd, oe);
        chk("R6 LSB-first reg read", rd, 8'h96);
        expect_wr(4'h7, 4'h2, 8'hC1);
        ser_xfer(1'b0, 8'h12, 8'hC1, rd, oe);
        ser_xfer(1'b1, 8'h92, 8'h00, rd, oe);
        chk("R7 MSB-first write readback", rd, 8'hC1);
        chk("R7 serial oe released", 8'(ser_doe), 8'h0);

        // R10: parallel activity ignored in serial mode
        par_acc(1'b0, 5'h00, 8'h03, rd, oe);
        par_acc(1'b0, 5'h15, 8'hEE, rd, oe);
        chk("R10 parallel oe off in serial mode", 8'(oe), 8'h0);
        ser_xfer(1'b0, 8'h80, 8'h00, rd, oe);
        chk("R10 page kept after parallel", rd, 8'h07);

        // R10: serial activity ignored in parallel mode
        sel_serial = 1'b0;
        wait_n(4);
        ser_xfer(1'b1, 8'h00, 8'h01, rd, oe);
        ser_xfer(1'b1, 8'h15, 8'hAB, rd, oe);
        par_acc(1'b1, 5'h00, 8'h00, rd, oe);
        chk("R10 page kept after serial", rd, 8'h07);

        // R2: unsupported stream mode
        sel_serial = 1'b1; sel_stream = 1'b1;
        wait_n(4);
        chk("R2 unsupported flag", 8'(mode_unsup), 8'h1);
        par_acc(1'b0, 5'h00, 8'h04, rd, oe);
        ser_xfer(1'b1, 8'h00, 8'h04, rd, oe);
        ser_xfer(1'b0, 8'h16, 8'h55, rd, oe);
        sel_serial = 1'b0; sel_stream = 1'b0;
        wait_n(4);
        chk("R2 flag clears", 8'(mode_unsup), 8'h0);
        par_acc(1'b1, 5'h00, 8'h00, rd, oe);
        chk("R2 page kept in stream mode", rd, 8'h07);
        par_acc(1'b1, 5'h16, 8'h00, rd, oe);
        chk("R2 reg kept in stream mode", rd, init_val(16 * 7 + 6));

        wait_n(4);
        chk("R4 scoreboard drained", 8'(exp_q.size()), 8'h0);
        finish_run();
    end
endmodule